// File: doc/BRIEF.md
# Banked Distributor Control Front End

This block is the register front end of an interrupt distributor. It keeps one two-bit control word: one bit turns on delivery for Group 0 interrupts, the other for Group 1. Software reaches that word through a byte-addressed register port, where each access carries a secure attribute. When the controller is configured with security support, a non-secure access sees a narrowed view: a single bit that stands for the Group 1 enable. There is no second copy of the word behind that view. The port also returns a read-only type value that gives how many interrupt lines the distributor supports.

Each CPU has a pending-request input and an interface enable. A CPU's request output goes high only when its request is pending, its interface is enabled, and at least one group enable in the control word is set. Two configuration inputs set whether security and interrupt groups are supported. They are expected to stay fixed while the block runs. The number of CPUs and the number of interrupt lines are elaboration parameters.

Top module: `dctl_dist_front`

## Requirements
- R1: After reset the control word is zero, every request output is low and the read-valid output is low.
- R2: A write at byte offset 0 using the full view stores data bits 1:0 when groups are supported (bit 0 = Group 0 enable, bit 1 = Group 1 enable). The higher data bits are dropped. A full-view read of offset 0 returns the stored word in bits 1:0 and zeros above.
- R3: When groups are not supported, a full-view write at offset 0 stores data bit 0 and clears bit 1.
- R4: With security support on, a non-secure read of offset 0 returns the Group 1 enable in bit 0 and zeros in every other bit.
- R5: With security support on, a non-secure write at offset 0 copies data bit 0 into the Group 1 enable and leaves the Group 0 enable unchanged.
- R6: With security support off, the secure attribute has no effect: every access uses the full view.
- R7: Writes at byte offsets 1, 2, 3, and at any offset other than 0, leave the control word unchanged. Reads of unmapped offsets return zero.
- R8: A read of byte offset 4 returns NUM_IRQ/32 - 1 in the low bits, under either view.
- R9: Read data and read-valid appear one cycle after the read strobe. Read-valid is low in any cycle that does not follow a strobe, and read data is zero while read-valid is low.
- R10: Each CPU's request output is registered. It equals pending AND interface enable AND (Group 0 enable OR Group 1 enable), sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sec_en | input | 1 | Security support present (static) |
| cfg_grp_en | input | 1 | Interrupt groups supported (static) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| bus_rdata | output | 32 | Read data |
| cpu_if_en | input | NUM_CPU | Per-CPU interface enable |
| cpu_pend | input | NUM_CPU | Per-CPU pending request |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench targets the alias path. It checks that a non-secure write changes only the Group 1 enable: a design that wrote data bit 0 into bit 0, or wrote the whole word, would switch Group 0 on or off. It checks that a non-secure read shifts bit 1 down to bit 0, which exposes a design that returns the raw word. It runs the groups-off and security-off configurations, where a design that ignores the configuration would keep bit 1 or narrow the view when it should not. It also writes offsets 1 to 3, which a design decoding only the word address would accept, and it drives request gating with only one group enabled, which catches a design that ANDs the two group enables instead of ORing them.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int DATA_W   = 32;
    localparam int OFF_CTL  = 0;
    localparam int OFF_TYPE = 4;

    // Which view of the control word an access uses
    typedef enum logic {
        VIEW_FULL  = 1'b0,
        VIEW_ALIAS = 1'b1
    } view_e;

    typedef struct packed {
        logic grp1_en;
        logic grp0_en;
    } ctl_word_t;

endpackage

// File: rtl/dctl_ctrl_reg.sv
module dctl_ctrl_reg
    import dctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  view_e             view,
    input  logic              grp_en,
    output ctl_word_t         ctl_q
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);

    typedef struct packed {
        ctl_word_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == A_CTL) begin
            if (view == VIEW_ALIAS) begin
                st_d.ctl.grp1_en = wdata[0];
            end else if (grp_en) begin
                st_d.ctl.grp0_en = wdata[0];
                st_d.ctl.grp1_en = wdata[1];
            end else begin
                st_d.ctl.grp0_en = wdata[0];
                st_d.ctl.grp1_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;

    // R5
    alias_keeps_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTL && view == VIEW_ALIAS)
        |=> (ctl_q.grp0_en == $past(ctl_q.grp0_en) && ctl_q.grp1_en == $past(wdata[0])));

    // R3
    no_groups_clears_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTL && view == VIEW_FULL && !grp_en)
        |=> (ctl_q.grp1_en == 1'b0));

    // R7
    other_offset_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == A_CTL)) |=> $stable(ctl_q));

endmodule

// File: rtl/dctl_rd_port.sv
module dctl_rd_port
    import dctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_IRQ = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  view_e             view,
    input  ctl_word_t         ctl,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_TYPE   = ADDR_W'(OFF_TYPE);
    localparam logic [DATA_W-1:0] TYPE_VAL = DATA_W'(NUM_IRQ / 32 - 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = rd_en;
        if (rd_en) begin
            if (addr == A_CTL) begin
                if (view == VIEW_ALIAS) begin
                    st_d.data[0] = ctl.grp1_en;
                end else begin
                    st_d.data[1:0] = ctl;
                end
            end else if (addr == A_TYPE) begin
                st_d.data = TYPE_VAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.valid;
    assign rdata  = st_q.data;

    // R9
    rvalid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R9
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    // R4
    alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTL && view == VIEW_ALIAS)
        |=> (rdata[DATA_W-1:1] == '0 && rdata[0] == $past(ctl.grp1_en)));

    // R8
    type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_TYPE) |=> rdata == TYPE_VAL);

endmodule

// File: rtl/dctl_irq_gate.sv
module dctl_irq_gate
    import dctl_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_word_t          ctl,
    input  logic [NUM_CPU-1:0] if_en,
    input  logic [NUM_CPU-1:0] pend,
    output logic [NUM_CPU-1:0] irq
);

    logic               dist_on;
    logic [NUM_CPU-1:0] irq_d, irq_q;

    assign dist_on = ctl.grp0_en | ctl.grp1_en;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_comb begin
            irq_d[c] = pend[c] & if_en[c] & dist_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    // R10
    dist_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == '0) |=> irq == '0);

    // R10
    if_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq & ~$past(if_en)) == '0);

endmodule

// File: rtl/dctl_dist_front.sv
module dctl_dist_front
    import dctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sec_en,
    input  logic               cfg_grp_en,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_secure,
    output logic               bus_rvalid,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_CPU-1:0] cpu_if_en,
    input  logic [NUM_CPU-1:0] cpu_pend,
    output logic [NUM_CPU-1:0] cpu_irq
);

    view_e     view;
    ctl_word_t ctl;

    // R6: the narrowed view exists only with security support
    assign view = (cfg_sec_en && !bus_secure) ? VIEW_ALIAS : VIEW_FULL;

    dctl_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .view   (view),
        .grp_en (cfg_grp_en),
        .ctl_q  (ctl)
    );

    dctl_rd_port #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_rd),
        .addr   (bus_addr),
        .view   (view),
        .ctl    (ctl),
        .rvalid (bus_rvalid),
        .rdata  (bus_rdata)
    );

    dctl_irq_gate #(.NUM_CPU(NUM_CPU)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .if_en (cpu_if_en),
        .pend  (cpu_pend),
        .irq   (cpu_irq)
    );

    // R6
    full_view_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !cfg_sec_en && cfg_grp_en)
        |=> ctl == $past(bus_wdata[1:0]));

endmodule

// File: tb/dctl_dist_front_test.sv
module dctl_dist_front_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int NUM_CPU    = 4;
    localparam int NUM_IRQ    = 96;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_sec_en = 1'b1;
    logic               cfg_grp_en = 1'b1;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_secure = 1'b1;
    logic               bus_rvalid;
    logic [31:0]        bus_rdata;
    logic [NUM_CPU-1:0] cpu_if_en = '0;
    logic [NUM_CPU-1:0] cpu_pend = '0;
    logic [NUM_CPU-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dctl_dist_front #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_sec_en(cfg_sec_en), .cfg_grp_en(cfg_grp_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_secure(bus_secure), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cpu_if_en(cpu_if_en), .cpu_pend(cpu_pend), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic sec, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(off); bus_secure = sec; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int off, input logic sec, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(off); bus_secure = sec;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check("R9 rvalid after strobe", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        check("R1 irq low", 32'(cpu_irq), 32'd0);
        check("R1 rvalid low", 32'(bus_rvalid), 32'd0);
        rd(0, 1'b1, d);
        check("R1 control word zero", d, 32'd0);
    endtask

    task automatic t_full_write();
        logic [31:0] d;
        cfg_sec_en = 1'b1; cfg_grp_en = 1'b1;
        wr(0, 1'b1, 32'hFFFF_FFFF); rd(0, 1'b1, d);
        check("R2 both bits, upper dropped", d, 32'd3);
        wr(0, 1'b1, 32'h0000_0002); rd(0, 1'b1, d);
        check("R2 group1 only", d, 32'd2);
        wr(0, 1'b1, 32'h8000_0001); rd(0, 1'b1, d);
        check("R2 group0 only", d, 32'd1);
    endtask

    task automatic t_groups_off();
        logic [31:0] d;
        cfg_grp_en = 1'b0;
        wr(0, 1'b1, 32'd3); rd(0, 1'b1, d);
        check("R3 bit1 cleared", d, 32'd1);
        wr(0, 1'b1, 32'd2); rd(0, 1'b1, d);
        check("R3 bit1 not stored", d, 32'd0);
        cfg_grp_en = 1'b1;
    endtask

    task automatic t_alias_read();
        logic [31:0] d;
        wr(0, 1'b1, 32'd2); rd(0, 1'b0, d);
        check("R4 alias shows group1", d, 32'd1);
        wr(0, 1'b1, 32'd1); rd(0, 1'b0, d);
        check("R4 alias hides group0", d, 32'd0);
    endtask

    task automatic t_alias_write();
        logic [31:0] d;
        wr(0, 1'b1, 32'd1);
        wr(0, 1'b0, 32'hFFFF_FFFE); rd(0, 1'b1, d);
        check("R5 bit0=0 keeps group0", d, 32'd1);
        wr(0, 1'b0, 32'd1); rd(0, 1'b1, d);
        check("R5 sets group1 only", d, 32'd3);
        wr(0, 1'b0, 32'd0); rd(0, 1'b1, d);
        check("R5 clears group1 only", d, 32'd1);
        wr(0, 1'b1, 32'd2);
        wr(0, 1'b0, 32'd2); rd(0, 1'b1, d);
        check("R5 data bit1 unused", d, 32'd0);
    endtask

    task automatic t_security_off();
        logic [31:0] d;
        cfg_sec_en = 1'b0;
        wr(0, 1'b0, 32'd3); rd(0, 1'b0, d);
        check("R6 non-secure gets full view", d, 32'd3);
        wr(0, 1'b0, 32'd2); rd(0, 1'b0, d);
        check("R6 full write from non-secure", d, 32'd2);
        cfg_sec_en = 1'b1;
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(0, 1'b1, 32'd3);
        for (int o = 1; o < 4; o++) wr(o, 1'b1, 32'd0);
        wr(8, 1'b1, 32'd0);
        wr(4, 1'b1, 32'd0);
        rd(0, 1'b1, d);
        check("R7 offsets 1-3,4,8 writes ignored", d, 32'd3);
        for (int o = 1; o < 4; o++) begin
            rd(o, 1'b1, d);
            check("R7 unmapped read zero", d, 32'd0);
        end
        rd(12'h0FC, 1'b1, d);
        check("R7 unmapped read zero high", d, 32'd0);
    endtask

    task automatic t_type();
        logic [31:0] d;
        rd(4, 1'b1, d);
        check("R8 type secure", d, 32'(NUM_IRQ/32 - 1));
        rd(4, 1'b0, d);
        check("R8 type non-secure", d, 32'(NUM_IRQ/32 - 1));
    endtask

    task automatic t_timing();
        @(negedge clk); #1;
        check("R9 idle rvalid low", 32'(bus_rvalid), 32'd0);
        check("R9 idle rdata zero", bus_rdata, 32'd0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(4);
        #1;
        check("R9 no same-cycle valid", 32'(bus_rvalid), 32'd0);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check("R9 data next cycle", bus_rdata, 32'(NUM_IRQ/32 - 1));
        @(negedge clk); #1;
        check("R9 valid drops", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic t_irq();
        wr(0, 1'b1, 32'd0);
        cpu_pend = '1; cpu_if_en = '1;
        settle();
        check("R10 distributor off", 32'(cpu_irq), 32'd0);
        wr(0, 1'b1, 32'd1); settle();
        check("R10 group0 on", 32'(cpu_irq), 32'hF);
        cpu_if_en = 4'b0101; settle();
        check("R10 interface gating", 32'(cpu_irq), 32'h5);
        wr(0, 1'b1, 32'd2); settle();
        check("R10 group1 on", 32'(cpu_irq), 32'h5);
        cpu_pend = 4'b0011; settle();
        check("R10 pending gating", 32'(cpu_irq), 32'h1);
        wr(0, 1'b0, 32'd0); settle();
        check("R10 off via alias", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        cpu_pend = '1; cpu_if_en = '1;
        wr(0, 1'b1, 32'd3);
        @(negedge clk); #1;
        check("R10 one cycle after word", 32'(cpu_irq), 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_write();
        t_groups_off();
        t_alias_read();
        t_alias_write();
        t_security_off();
        t_ignored();
        t_type();
        t_timing();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule